// File: doc/BRIEF.md
# Two-Wire Bus Slave Controller with Per-Transfer Byte Count

This block is a slave on a two-wire serial bus (SCL clock, SDA data, both open-drain). It runs on its own system clock, passes both bus lines through a synchronizer, and decodes START and STOP conditions itself. It compares the 7-bit address after each START with a programmed address. On a match, the R/W bit decides whether the slave receives data or transmits it. Bytes travel most significant bit first.

A byte-count register sets how many data bytes one addressed transfer carries. The counter reloads on every address match. In receive mode the slave acknowledges bytes up to that count and refuses the rest. In transmit mode it sends bytes from a holding register up to that count and raises a ready flag whenever it needs a new one. Bytes past the count are sent as all ones.

Status flags report several events: direction, address match, byte finished, NAK received, receive data ready, transmit data wanted, and transfer complete. Software reads the flags through a small register port. It clears the event flags by writing ones to them.

Top module: `i2c_bytecount_slave`

## Requirements
- R1: After a START, the slave pulls SDA low during the ninth SCL clock only when the seven address bits equal register 0 bits [6:0]. With any other address it leaves SDA released for every clock until the next START.
- R2: Status register 4 bit 2 (direction) becomes 1 for a read (R/W = 1) and 0 for a write. It takes its new value one clock cycle after status bit 3 (address match) is set, and not in the same cycle.
- R3: In receive mode, each data byte is assembled MSB first and acknowledged while the count allows it. The byte is then placed in register 3, and status bit 1 (receive ready) is set.
- R4: The count in register 1 reloads at every address match. Received bytes past the count get a NAK and leave register 3 and bit 1 untouched. A count of 0 refuses every data byte, but the address is still acknowledged.
- R5: In transmit mode, the byte in register 2 is shifted out MSB first. Status bit 0 (transmit wanted) is set at a read address match. It is also set each time a byte is loaded while more than one byte of the count remains. A write to register 2 clears bit 0. Bytes past the count are sent as 0xFF.
- R6: Status bit 4 (byte finished) and, in transmit mode when the master leaves SDA high, bit 5 (NAK) are set on the second clock edge after the first synchronizer stage captures the rising SCL of the acknowledge clock.
- R7: After a NAK from the master, the slave keeps SDA released until the next START or STOP.
- R8: Status bit 6 (complete) is set at a STOP that ends a transfer with an address match. A repeated START does not set it, and neither does a transfer that never matched.
- R9: Writing register 4 clears the bits among 1, 3, 4, 5 and 6 that are written as 1. Bits written as 0 keep their value.
- R10: Out of reset all status bits are 0 and SDA is released. SCL is never driven, and SDA drive changes only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| scl_o | output | 1 | SCL output value (always 0) |
| scl_oe | output | 1 | SCL pull-down enable (never set) |
| sda_i | input | 1 | SDA line level |
| sda_o | output | 1 | SDA output value (always 0) |
| sda_oe | output | 1 | SDA pull-down enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 address, 1 count, 2 transmit data, 3 receive data, 4 status |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |

## Verification
The bench sends a receive byte one past the count and expects a NAK with register 3 unchanged. A design that never compares the counter would accept that byte. The bench also splits a write with a repeated START and expects both later bytes to be acknowledged. A design that reloads the counter only after STOP would refuse the last byte, and one that treats the repeated START as an end would raise the complete flag early. For the acknowledge clock, the bench drives SCL high itself and reads the byte-finished and NAK flags on the three following cycles, so a flag that comes one cycle early or late is caught. A multi-byte read checks that the transmit-wanted flag follows the count and that the byte past the count comes out as 0xFF.

// File: rtl/i2c_slv_pkg.sv
package i2c_slv_pkg;
   localparam int REG_AW = 3;

   localparam logic [REG_AW-1:0] RA_OWN = 3'd0;
   localparam logic [REG_AW-1:0] RA_CNT = 3'd1;
   localparam logic [REG_AW-1:0] RA_TXD = 3'd2;
   localparam logic [REG_AW-1:0] RA_RXD = 3'd3;
   localparam logic [REG_AW-1:0] RA_STS = 3'd4;

   localparam int SB_TXW  = 0;
   localparam int SB_RXR  = 1;
   localparam int SB_DIR  = 2;
   localparam int SB_HIT  = 3;
   localparam int SB_BYTE = 4;
   localparam int SB_NAK  = 5;
   localparam int SB_DONE = 6;
   localparam int SB_W    = 7;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_ADDR,
      PH_AACK,
      PH_RX,
      PH_RACK,
      PH_TX,
      PH_TACK,
      PH_SKIP
   } phase_t;
endpackage

// File: rtl/i2c_slv_sync_line.sv
module i2c_slv_sync_line #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_s,
   output logic line_q
);
   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain  <= '1;
         line_q <= 1'b1;
      end else begin
         chain  <= {chain[STAGES-2:0], line_i};
         line_q <= chain[STAGES-1];
      end
   end

   assign line_s = chain[STAGES-1];
endmodule

// File: rtl/i2c_slv_sync.sv
module i2c_slv_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic scl_s,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   localparam int NLINES = 2;

   logic [NLINES-1:0] raw, cur, prev;

   assign raw = {sda_i, scl_i};

   for (genvar k = 0; k < NLINES; k++) begin : g_line
      i2c_slv_sync_line #(.STAGES(STAGES)) u_line (
         .clk    (clk),
         .rst_n  (rst_n),
         .line_i (raw[k]),
         .line_s (cur[k]),
         .line_q (prev[k])
      );
   end

   assign scl_s     = cur[0];
   assign sda_s     = cur[1];
   assign scl_rise  = cur[0] & ~prev[0];
   assign scl_fall  = ~cur[0] & prev[0];
   assign start_det = cur[0] & prev[0] & prev[1] & ~cur[1];
   assign stop_det  = cur[0] & prev[0] & ~prev[1] & cur[1];
endmodule

// File: rtl/i2c_slv_engine.sv
module i2c_slv_engine
   import i2c_slv_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sda_s,
   input  logic             scl_rise,
   input  logic             scl_fall,
   input  logic             start_det,
   input  logic             stop_det,
   input  logic [6:0]       own_addr,
   input  logic [CNT_W-1:0] byte_cnt,
   input  logic [7:0]       tx_hold,
   output logic             sda_drive,
   output logic             ev_match,
   output logic             ev_rw,
   output logic             ev_btf,
   output logic             ev_nak,
   output logic             ev_rx,
   output logic [7:0]       rx_byte,
   output logic             ev_txreq,
   output logic             ev_done
);
   localparam logic [2:0] LAST_BIT = 3'd7;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   phase_t           phase;
   logic [7:0]       shreg;
   logic [2:0]       bitcnt;
   logic             full;
   logic             rw_q;
   logic             take;
   logic             nak_q;
   logic             active;
   logic [CNT_W-1:0] left;

   logic             hit;
   logic             load_now;
   logic [7:0]       next_tx;

   assign hit      = (shreg[7:1] == own_addr);
   assign next_tx  = (left != '0) ? tx_hold : 8'hFF;
   assign load_now = scl_fall && !start_det && !stop_det &&
                     (((phase == PH_AACK) && rw_q) ||
                      ((phase == PH_TACK) && !nak_q));

   assign ev_match = (phase == PH_ADDR) && scl_fall && full && hit &&
                     !start_det && !stop_det;
   assign ev_rw    = shreg[0];
   assign ev_rx    = (phase == PH_RACK) && scl_rise && take;
   assign ev_nak   = (phase == PH_TACK) && scl_rise && sda_s;
   assign ev_btf   = ev_rx || ((phase == PH_TACK) && scl_rise);
   assign rx_byte  = shreg;
   assign ev_txreq = (ev_match && shreg[0]) || (load_now && (left > ONE));
   assign ev_done  = stop_det && active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         shreg     <= '0;
         bitcnt    <= '0;
         full      <= 1'b0;
         rw_q      <= 1'b0;
         take      <= 1'b0;
         nak_q     <= 1'b0;
         active    <= 1'b0;
         left      <= '0;
         sda_drive <= 1'b0;
      end else if (stop_det) begin
         phase     <= PH_IDLE;
         active    <= 1'b0;
         sda_drive <= 1'b0;
      end else if (start_det) begin
         phase     <= PH_ADDR;
         bitcnt    <= '0;
         full      <= 1'b0;
         sda_drive <= 1'b0;
      end else if (load_now) begin
         shreg     <= next_tx;
         sda_drive <= ~next_tx[7];
         bitcnt    <= '0;
         full      <= 1'b0;
         phase     <= PH_TX;
      end else begin
         unique case (phase)
            PH_ADDR, PH_RX: begin
               if (scl_rise) begin
                  shreg <= {shreg[6:0], sda_s};
                  if (bitcnt == LAST_BIT) full <= 1'b1;
                  else                    bitcnt <= bitcnt + 3'd1;
               end else if (scl_fall && full) begin
                  full <= 1'b0;
                  if (phase == PH_ADDR) begin
                     if (hit) begin
                        phase     <= PH_AACK;
                        sda_drive <= 1'b1;
                        rw_q      <= shreg[0];
                        left      <= byte_cnt;
                        active    <= 1'b1;
                     end else begin
                        phase <= PH_SKIP;
                     end
                  end else begin
                     phase     <= PH_RACK;
                     take      <= (left != '0);
                     sda_drive <= (left != '0);
                  end
               end
            end
            PH_AACK: begin
               if (scl_fall) begin
                  sda_drive <= 1'b0;
                  bitcnt    <= '0;
                  phase     <= PH_RX;
               end
            end
            PH_RACK: begin
               if (scl_rise && take) begin
                  left <= left - ONE;
               end else if (scl_fall) begin
                  sda_drive <= 1'b0;
                  bitcnt    <= '0;
                  phase     <= PH_RX;
               end
            end
            PH_TX: begin
               if (scl_rise) begin
                  if (bitcnt == LAST_BIT) full <= 1'b1;
                  else                    bitcnt <= bitcnt + 3'd1;
               end else if (scl_fall) begin
                  if (full) begin
                     full      <= 1'b0;
                     sda_drive <= 1'b0;
                     phase     <= PH_TACK;
                  end else begin
                     shreg     <= {shreg[6:0], 1'b1};
                     sda_drive <= ~shreg[6];
                  end
               end
            end
            PH_TACK: begin
               if (scl_rise) begin
                  nak_q <= sda_s;
                  if (left != '0) left <= left - ONE;
               end else if (scl_fall && nak_q) begin
                  phase <= PH_SKIP;
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/i2c_slv_regs.sv
module i2c_slv_regs
   import i2c_slv_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              ev_match,
   input  logic              ev_rw,
   input  logic              ev_btf,
   input  logic              ev_nak,
   input  logic              ev_rx,
   input  logic [7:0]        rx_byte,
   input  logic              ev_txreq,
   input  logic              ev_done,
   output logic [6:0]        own_addr,
   output logic [CNT_W-1:0]  byte_cnt,
   output logic [7:0]        tx_hold,
   output logic [SB_W-1:0]   status
);
   logic [7:0]      rx_hold;
   logic            dir_pend;
   logic            dir_rw;
   logic            wr_own, wr_cnt, wr_txd, wr_sts;
   logic [SB_W-1:0] w1c;

   assign wr_own = reg_we && (reg_addr == RA_OWN);
   assign wr_cnt = reg_we && (reg_addr == RA_CNT);
   assign wr_txd = reg_we && (reg_addr == RA_TXD);
   assign wr_sts = reg_we && (reg_addr == RA_STS);
   assign w1c    = wr_sts ? reg_wdata[SB_W-1:0] : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_addr <= '0;
         byte_cnt <= '0;
         tx_hold  <= '0;
         rx_hold  <= '0;
         status   <= '0;
         dir_pend <= 1'b0;
         dir_rw   <= 1'b0;
      end else begin
         if (wr_own) own_addr <= reg_wdata[6:0];
         if (wr_cnt) byte_cnt <= reg_wdata[CNT_W-1:0];
         if (wr_txd) tx_hold  <= reg_wdata;
         if (ev_rx)  rx_hold  <= rx_byte;

         dir_pend <= ev_match;
         dir_rw   <= ev_rw;
         if (dir_pend) status[SB_DIR] <= dir_rw;

         if (ev_txreq)    status[SB_TXW] <= 1'b1;
         else if (wr_txd) status[SB_TXW] <= 1'b0;

         if (ev_rx)                status[SB_RXR] <= 1'b1;
         else if (w1c[SB_RXR])     status[SB_RXR] <= 1'b0;

         if (ev_match)             status[SB_HIT] <= 1'b1;
         else if (w1c[SB_HIT])     status[SB_HIT] <= 1'b0;

         if (ev_btf)               status[SB_BYTE] <= 1'b1;
         else if (w1c[SB_BYTE])    status[SB_BYTE] <= 1'b0;

         if (ev_nak)               status[SB_NAK] <= 1'b1;
         else if (w1c[SB_NAK])     status[SB_NAK] <= 1'b0;

         if (ev_done)              status[SB_DONE] <= 1'b1;
         else if (w1c[SB_DONE])    status[SB_DONE] <= 1'b0;
      end
   end

   always_comb begin
      unique case (reg_addr)
         RA_OWN:  reg_rdata = {1'b0, own_addr};
         RA_CNT:  reg_rdata = 8'(byte_cnt);
         RA_TXD:  reg_rdata = tx_hold;
         RA_RXD:  reg_rdata = rx_hold;
         RA_STS:  reg_rdata = {{(8-SB_W){1'b0}}, status};
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/i2c_bytecount_slave.sv
module i2c_bytecount_slave
   import i2c_slv_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int CNT_W       = 8
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   output logic       scl_o,
   output logic       scl_oe,
   input  logic       sda_i,
   output logic       sda_o,
   output logic       sda_oe,
   input  logic       reg_we,
   input  logic [2:0] reg_addr,
   input  logic [7:0] reg_wdata,
   output logic [7:0] reg_rdata
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
      $error("CNT_W must lie between 1 and 8");
   end

   logic             scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
   logic [6:0]       own_addr;
   logic [CNT_W-1:0] byte_cnt;
   logic [7:0]       tx_hold;
   logic [7:0]       rx_byte;
   logic             ev_match, ev_rw, ev_btf, ev_nak, ev_rx, ev_txreq, ev_done;
   logic [SB_W-1:0]  status;

   assign scl_o  = 1'b0;
   assign scl_oe = 1'b0;
   assign sda_o  = 1'b0;

   i2c_slv_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2c_slv_engine #(.CNT_W(CNT_W)) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .own_addr  (own_addr),
      .byte_cnt  (byte_cnt),
      .tx_hold   (tx_hold),
      .sda_drive (sda_oe),
      .ev_match  (ev_match),
      .ev_rw     (ev_rw),
      .ev_btf    (ev_btf),
      .ev_nak    (ev_nak),
      .ev_rx     (ev_rx),
      .rx_byte   (rx_byte),
      .ev_txreq  (ev_txreq),
      .ev_done   (ev_done)
   );

   i2c_slv_regs #(.CNT_W(CNT_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .ev_match  (ev_match),
      .ev_rw     (ev_rw),
      .ev_btf    (ev_btf),
      .ev_nak    (ev_nak),
      .ev_rx     (ev_rx),
      .rx_byte   (rx_byte),
      .ev_txreq  (ev_txreq),
      .ev_done   (ev_done),
      .own_addr  (own_addr),
      .byte_cnt  (byte_cnt),
      .tx_hold   (tx_hold),
      .status    (status)
   );
endmodule

// File: rtl/i2c_slv_chk.sv
module i2c_slv_chk
   import i2c_slv_pkg::*;
(
   input logic            clk,
   input logic            rst_n,
   input logic            ev_match,
   input logic            ev_rw,
   input logic            stop_det,
   input logic            scl_s,
   input logic            scl_rise,
   input logic            sda_oe,
   input logic [SB_W-1:0] status
);
   a_r2_dir_holds_at_match: assert property (@(posedge clk) disable iff (!rst_n)
      ev_match |=> (status[SB_DIR] == $past(status[SB_DIR])));

   a_r2_dir_after_match: assert property (@(posedge clk) disable iff (!rst_n)
      ev_match |=> ##1 (status[SB_DIR] == $past(ev_rw, 2)));

   a_r6_byte_on_scl_rise: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[SB_BYTE]) |-> $past(scl_rise));

   a_r6_nak_only_transmit: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[SB_NAK]) |-> status[SB_DIR]);

   a_r8_done_at_stop: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[SB_DONE]) |-> $past(stop_det));

   a_r10_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> (!$past(scl_s) || $past(stop_det)));
endmodule

bind i2c_bytecount_slave i2c_slv_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ev_match (ev_match),
   .ev_rw    (ev_rw),
   .stop_det (stop_det),
   .scl_s    (scl_s),
   .scl_rise (scl_rise),
   .sda_oe   (sda_oe),
   .status   (status)
);

// File: tb/tb_i2c_bytecount_slave.sv
`timescale 1ns/1ps
module tb_i2c_bytecount_slave;
   localparam int Q = 8;
   localparam logic [2:0] A_OWN = 3'd0, A_CNT = 3'd1, A_TXD = 3'd2,
                          A_RXD = 3'd3, A_STS = 3'd4;
   localparam logic [6:0] MY_ADDR = 7'h3A;
   localparam logic [7:0] CLR_ALL = 8'h7A;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda = 1'b1;
   logic scl_o, scl_oe, sda_o, sda_oe;
   logic reg_we = 1'b0;
   logic [2:0] reg_addr = A_STS;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic scl_bus, sda_bus;
   int checks = 0, errors = 0;

   always #10 clk = ~clk;

   assign scl_bus = m_scl & (scl_oe ? scl_o : 1'b1);
   assign sda_bus = m_sda & (sda_oe ? sda_o : 1'b1);

   i2c_bytecount_slave dut (
      .clk(clk), .rst_n(rst_n),
      .scl_i(scl_bus), .scl_o(scl_o), .scl_oe(scl_oe),
      .sda_i(sda_bus), .sda_o(sda_o), .sda_oe(sda_oe),
      .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wq(input int n = Q);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0; reg_addr = A_STS;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      reg_addr = a; #1; d = reg_rdata; reg_addr = A_STS;
   endtask

   task automatic bus_start;
      m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); m_sda = 1'b0; wq(); m_scl = 1'b0; wq();
   endtask

   task automatic bus_stop;
      m_sda = 1'b0; wq(); m_scl = 1'b1; wq(); m_sda = 1'b1; wq();
   endtask

   task automatic bit_out(input logic b);
      m_sda = b; wq(); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq();
   endtask

   task automatic bit_in(output logic b);
      m_sda = 1'b1; wq(); m_scl = 1'b1; wq(); b = sda_bus; wq(); m_scl = 1'b0; wq();
   endtask

   task automatic send_byte(input logic [7:0] d, output logic acked);
      logic b;
      for (int i = 7; i >= 0; i--) bit_out(d[i]);
      bit_in(b);
      acked = ~b;
   endtask

   task automatic recv_byte(output logic [7:0] d);
      logic b;
      for (int i = 7; i >= 0; i--) begin
         bit_in(b);
         d[i] = b;
      end
   endtask

   task automatic t_reset;
      logic [7:0] s;
      rd(A_STS, s);
      chk("R10 reset status", s, 8'h00);
      chk("R10 reset sda released", {7'b0, sda_oe}, 8'h00);
      chk("R10 scl never driven", {7'b0, scl_oe}, 8'h00);
   endtask

   task automatic t_receive;
      logic a; logic [7:0] s;
      wr(A_OWN, {1'b0, MY_ADDR}); wr(A_CNT, 8'd2); wr(A_STS, CLR_ALL);
      bus_start;
      send_byte({MY_ADDR, 1'b0}, a);
      chk("R1 address ack", {7'b0, a}, 8'h01);
      rd(A_STS, s);
      chk("R2 match set, direction write", s & 8'h0C, 8'h08);
      send_byte(8'hA5, a);
      chk("R3 first byte ack", {7'b0, a}, 8'h01);
      rd(A_RXD, s); chk("R3 first byte stored", s, 8'hA5);
      rd(A_STS, s); chk("R3 receive ready", s & 8'h02, 8'h02);
      wr(A_STS, 8'h02);
      send_byte(8'h3C, a);
      chk("R3 second byte ack", {7'b0, a}, 8'h01);
      rd(A_RXD, s); chk("R3 second byte stored", s, 8'h3C);
      wr(A_STS, 8'h02);
      send_byte(8'h77, a);
      chk("R4 byte past count refused", {7'b0, a}, 8'h00);
      rd(A_RXD, s); chk("R4 refused byte discarded", s, 8'h3C);
      rd(A_STS, s); chk("R4 no receive ready for refused byte", s & 8'h02, 8'h00);
      bus_stop;
      rd(A_STS, s); chk("R8 complete at stop", s & 8'h40, 8'h40);
   endtask

   task automatic t_nomatch;
      logic a; logic [7:0] s;
      wr(A_STS, CLR_ALL);
      bus_start;
      send_byte({7'h11, 1'b0}, a);
      chk("R1 foreign address not acked", {7'b0, a}, 8'h00);
      send_byte(8'h00, a);
      chk("R1 foreign data not acked", {7'b0, a}, 8'h00);
      bus_stop;
      rd(A_STS, s);
      chk("R8 no match no complete", s & 8'h48, 8'h00);
   endtask

   task automatic t_tx_single;
      logic a; logic [7:0] s, d;
      wr(A_CNT, 8'd1); wr(A_TXD, 8'hC3); wr(A_STS, CLR_ALL);
      bus_start;
      send_byte({MY_ADDR, 1'b1}, a);
      chk("R1 read address ack", {7'b0, a}, 8'h01);
      rd(A_STS, s);
      chk("R5 want flag at read match, R2 direction read", s & 8'h05, 8'h05);
      wr(A_TXD, 8'h5A);
      recv_byte(d);
      chk("R5 single byte sent", d, 8'hC3);
      rd(A_STS, s);
      chk("R5 no request when count exhausted", s & 8'h01, 8'h00);
      m_sda = 1'b1; wq();
      m_scl = 1'b1;
      @(negedge clk); rd(A_STS, s);
      chk("R6 flags clear one cycle after edge", s & 8'h30, 8'h00);
      @(negedge clk); rd(A_STS, s);
      chk("R6 flags clear two cycles after edge", s & 8'h30, 8'h00);
      @(negedge clk); rd(A_STS, s);
      chk("R6 byte and nak flags on time", s & 8'h30, 8'h30);
      wq(2*Q - 3); m_scl = 1'b0; wq(2*Q);
      chk("R7 sda released after nak", {7'b0, sda_oe}, 8'h00);
      m_scl = 1'b1; wq(Q);
      chk("R7 sda released on extra clock", {7'b0, sda_oe}, 8'h00);
      m_scl = 1'b0; wq(Q);
      bus_stop;
      rd(A_STS, s); chk("R8 complete after read", s & 8'h40, 8'h40);
   endtask

   task automatic t_tx_multi;
      logic a; logic [7:0] s, d;
      wr(A_CNT, 8'd3); wr(A_TXD, 8'h81); wr(A_STS, CLR_ALL);
      bus_start;
      send_byte({MY_ADDR, 1'b1}, a);
      wr(A_TXD, 8'h42);
      recv_byte(d); chk("R5 byte 1", d, 8'h81);
      rd(A_STS, s); chk("R5 want cleared by write", s & 8'h01, 8'h00);
      bit_out(1'b0);
      rd(A_STS, s); chk("R5 want set on load with bytes left", s & 8'h01, 8'h01);
      rd(A_STS, s); chk("R6 ack gives byte flag, no nak", s & 8'h30, 8'h10);
      wr(A_TXD, 8'hE7);
      recv_byte(d); chk("R5 byte 2", d, 8'h42);
      bit_out(1'b0);
      rd(A_STS, s); chk("R5 no want on last counted byte", s & 8'h01, 8'h00);
      recv_byte(d); chk("R5 byte 3", d, 8'hE7);
      bit_out(1'b0);
      recv_byte(d); chk("R5 byte past count is ones", d, 8'hFF);
      bit_out(1'b1);
      rd(A_STS, s); chk("R6 nak recorded", s & 8'h20, 8'h20);
      bus_stop;
   endtask

   task automatic t_repeat_start;
      logic a; logic [7:0] s;
      wr(A_CNT, 8'd2); wr(A_STS, CLR_ALL);
      bus_start;
      send_byte({MY_ADDR, 1'b0}, a);
      send_byte(8'h11, a);
      bus_start;
      rd(A_STS, s); chk("R8 no complete at repeated start", s & 8'h40, 8'h00);
      send_byte({MY_ADDR, 1'b0}, a);
      chk("R1 ack after repeated start", {7'b0, a}, 8'h01);
      send_byte(8'h22, a);
      send_byte(8'h33, a);
      chk("R4 count reloaded at second match", {7'b0, a}, 8'h01);
      rd(A_RXD, s); chk("R3 last byte stored", s, 8'h33);
      bus_stop;
      rd(A_STS, s); chk("R8 complete after repeated-start transfer", s & 8'h40, 8'h40);
   endtask

   task automatic t_w1c;
      logic [7:0] s;
      wr(A_STS, 8'h00);
      rd(A_STS, s); chk("R9 zero write keeps flags", s & 8'h5A, 8'h5A);
      wr(A_STS, 8'h40);
      rd(A_STS, s); chk("R9 clears only written bit", s & 8'h5A, 8'h1A);
      wr(A_STS, CLR_ALL);
      rd(A_STS, s); chk("R9 all event flags cleared", s & 8'h7A, 8'h00);
   endtask

   task automatic t_count_zero;
      logic a; logic [7:0] s;
      wr(A_CNT, 8'd0);
      bus_start;
      send_byte({MY_ADDR, 1'b0}, a);
      chk("R4 address acked with zero count", {7'b0, a}, 8'h01);
      send_byte(8'h99, a);
      chk("R4 zero count refuses data", {7'b0, a}, 8'h00);
      rd(A_RXD, s); chk("R4 zero count keeps receive data", s, 8'h33);
      bus_stop;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      wq(4);
      rst_n = 1'b1;
      wq(4);
      t_reset;
      t_receive;
      t_nomatch;
      t_tx_single;
      t_tx_multi;
      t_repeat_start;
      t_w1c;
      t_count_zero;
      wq(10);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule